// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block turns pairs of 18-bit two's complement samples (one left word, one right word, taken at the same sampling instant) into a single-wire serial audio stream. Bits leave most significant first, change on the falling edge of the bit clock and are sampled by the receiver on the rising edge. A word clock marks which channel is being sent. Two frame layouts are offered. In the left-justified layout the word clock edge itself launches the MSB and a high word clock marks the left channel. In the I2S layout the MSB trails the word clock edge by one bit period and a low word clock marks the left channel.

All logic runs on the master clock `mclk`. With `slave_mode` low the port is clock master: it divides `mclk` by 4 for the bit clock and by 256 for the word clock, giving 64 bit periods per frame. With `slave_mode` high both clocks come in from outside, are resynchronised into the `mclk` domain, and their edges pace the same transmit state machine. The transmit machine has four states: IDLE (after reset, until the first word clock transition), LEAD (the one-bit gap of the I2S layout), DATA (shifting the 18 bits) and PAD (driving zero for the rest of the half-frame). Its transitions are: any state to LEAD (half start, I2S) or to DATA (half start, left-justified); LEAD to DATA on the next bit clock fall; DATA to DATA on each fall until 18 bits are out, then DATA to PAD; PAD stays in PAD until the next half start.

Samples are offered with a one-cycle `word_valid` strobe and parked in a pending register. At the start of each left half the pending pair is captured, so a strobe in the middle of a frame cannot tear the pair being sent.

Top module: `audio_serial_tx`

## Requirements
- R1: Each channel word is 18 bits, two's complement, and is transmitted MSB first, one bit per bit clock period.
- R2: In master mode `sclk_out` is `mclk`/4 (high for 2 and low for 2 `mclk` cycles), `lrck_out` has a period of 256 `mclk` cycles, and `lrck_out` only changes in the cycle where `sclk_out` falls.
- R3: In the left-justified layout (`fmt_i2s`=0) the MSB of the new channel appears on `sdata` in the same cycle as the word clock transition, and the other 17 bits follow on the next 17 falling bit clock edges.
- R4: In the I2S layout (`fmt_i2s`=1) `sdata` is 0 for the first bit period of each half-frame and the MSB appears on the first falling bit clock edge after the word clock transition.
- R5: In master mode `sdata` changes only in cycles where `sclk_out` falls, so it is stable around every rising edge.
- R6: Each frame sends the left word first, then the right word; the word clock is 1 during the left half in the left-justified layout and 0 during the left half in the I2S layout.
- R7: Both words of a frame are taken from the pending pair at the start of that frame's left half; a `word_valid` strobe during a frame affects neither word of that frame but is sent in the next one.
- R8: Every bit period of a half-frame that carries no data bit (after the 18th bit, and the leading gap in the I2S layout) drives `sdata` to 0.
- R9: In slave mode the port is paced by `sclk_in` and `lrck_in`, each passed through a 2-flop synchroniser; `sdata` changes 3 `mclk` cycles after a falling `sclk_in` edge, so `sclk_in` must stay high and low for at least 4 `mclk` cycles each; `sclk_out` and `lrck_out` are held at 0.
- R10: In slave mode a word clock transition always starts the next channel, so with 32 bit clocks per frame the word is cut short: the left-justified layout delivers the top 16 bits and the I2S layout the top 15 bits.
- R11: During reset and until the first word clock transition `sdata` is 0 and `sclk_out` is 0; in master mode `lrck_out` sits at the left-half level (1 left-justified, 0 I2S); the pending and held words reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1 = bit and word clocks are inputs, 0 = generated here |
| fmt_i2s | input | 1 | 1 = I2S layout, 0 = left-justified layout |
| word_valid | input | 1 | One-cycle strobe: a new sample pair is on the word inputs |
| left_word | input | 18 | Left channel sample, two's complement |
| right_word | input | 18 | Right channel sample, two's complement |
| sclk_in | input | 1 | External bit clock (slave mode) |
| lrck_in | input | 1 | External word clock (slave mode) |
| sclk_out | output | 1 | Generated bit clock (master mode), else 0 |
| lrck_out | output | 1 | Generated word clock (master mode), else 0 |
| sdata | output | 1 | Serial audio data |

## Verification
The bench decodes the stream the way a receiver would, sampling on each rising bit clock, so a word clock with the wrong polarity shows up as swapped channels and a missing or extra I2S gap shows up as words shifted by one bit. It writes a new pair just after a left half starts and checks that the frame in flight still carries the old pair, which catches a design that loads the shift register straight from the inputs. It checks the extreme codes (most negative, most positive, all ones) and bits sampled in the non-data slots, which expose a design that keeps shifting past the 18th bit. A short slave frame of 32 bit clocks checks that a word clock transition truncates the word rather than letting it run into the other channel.

// File: rtl/aso_pkg.sv
package aso_pkg;

    // Transmit state of one half-frame
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_DATA,
        ST_PAD
    } tx_state_e;

    // Timing events seen in the current mclk cycle
    typedef struct packed {
        logic fall;        // bit clock falls in this cycle
        logic half_start;  // word clock changes in this cycle
        logic left;        // the half that starts is the left one
    } bit_evt_t;

endpackage

// File: rtl/aso_master_timer.sv
module aso_master_timer
    import aso_pkg::*;
#(
    parameter int SCLK_DIV_LOG2 = 2,
    parameter int LRCK_DIV_LOG2 = 8
) (
    input  logic     mclk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     fmt_i2s,
    output logic     sclk_o,
    output logic     lrck_o,
    output bit_evt_t evt
);
    localparam int CW = LRCK_DIV_LOG2;

    logic [CW-1:0] div_q;
    logic          last_phase;
    logic          last_slot;

    always_ff @(posedge mclk) begin
        if (!rst_n || !enable) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign last_phase = &div_q[SCLK_DIV_LOG2-1:0];
    assign last_slot  = &div_q[CW-2:SCLK_DIV_LOG2];

    assign evt.fall       = enable && rst_n && last_phase;
    assign evt.half_start = enable && rst_n && last_phase && last_slot;
    // the next half is the left one when the top bit wraps back to 0
    assign evt.left       = div_q[CW-1];

    assign sclk_o = enable && div_q[SCLK_DIV_LOG2-1];
    assign lrck_o = enable && (fmt_i2s ? div_q[CW-1] : !div_q[CW-1]);

endmodule

// File: rtl/aso_slave_sync.sv
module aso_slave_sync
    import aso_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     mclk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     fmt_i2s,
    input  logic     sclk_i,
    input  logic     lrck_i,
    output bit_evt_t evt
);
    localparam int SW = SYNC_STAGES + 1;

    logic [SW-1:0] sck_sh;
    logic [SW-1:0] lr_sh;
    logic          sck_now;
    logic          sck_old;
    logic          lr_now;
    logic          lr_old;

    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            sck_sh <= '0;
            lr_sh  <= '0;
        end else begin
            sck_sh <= {sck_sh[SW-2:0], sclk_i};
            lr_sh  <= {lr_sh[SW-2:0], lrck_i};
        end
    end

    assign sck_now = sck_sh[SW-2];
    assign sck_old = sck_sh[SW-1];
    assign lr_now  = lr_sh[SW-2];
    assign lr_old  = lr_sh[SW-1];

    assign evt.fall       = enable && sck_old && !sck_now;
    assign evt.half_start = enable && (lr_old != lr_now);
    assign evt.left       = fmt_i2s ? !lr_now : lr_now;

endmodule

// File: rtl/aso_word_hold.sv
module aso_word_hold #(
    parameter int WORD_W = 18
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    input  logic              capture,
    output logic [WORD_W-1:0] frame_left,
    output logic [WORD_W-1:0] frame_right
);
    logic [WORD_W-1:0] pend_l_q;
    logic [WORD_W-1:0] pend_r_q;
    logic [WORD_W-1:0] held_r_q;

    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            pend_l_q <= '0;
            pend_r_q <= '0;
        end else if (word_valid) begin
            pend_l_q <= left_word;
            pend_r_q <= right_word;
        end
    end

    // the left word goes straight into the shifter at capture,
    // the right word waits here for its half
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            held_r_q <= '0;
        end else if (capture) begin
            held_r_q <= pend_r_q;
        end
    end

    assign frame_left  = pend_l_q;
    assign frame_right = held_r_q;

endmodule

// File: rtl/aso_tx_fsm.sv
module aso_tx_fsm
    import aso_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              fmt_i2s,
    input  bit_evt_t          evt,
    input  logic [WORD_W-1:0] frame_left,
    input  logic [WORD_W-1:0] frame_right,
    output logic              sdata
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W);

    tx_state_e         state_q;
    tx_state_e         state_d;
    logic [CNT_W-1:0]  sent_q;
    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] new_word;
    logic              sdata_q;

    assign new_word = evt.left ? frame_left : frame_right;

    always_comb begin
        state_d = state_q;
        if (evt.half_start) begin
            state_d = fmt_i2s ? ST_LEAD : ST_DATA;
        end else if (evt.fall) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_LEAD: state_d = ST_DATA;
                ST_DATA: state_d = (sent_q == LAST_CNT) ? ST_PAD : ST_DATA;
                ST_PAD:  state_d = ST_PAD;
            endcase
        end
    end

    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            sdata_q <= 1'b0;
            shreg_q <= '0;
            sent_q  <= '0;
        end else if (evt.half_start) begin
            if (fmt_i2s) begin
                sdata_q <= 1'b0;
                shreg_q <= new_word;
                sent_q  <= '0;
            end else begin
                sdata_q <= new_word[WORD_W-1];
                shreg_q <= {new_word[WORD_W-2:0], 1'b0};
                sent_q  <= CNT_W'(1);
            end
        end else if (evt.fall) begin
            unique case (state_q)
                ST_LEAD: begin
                    sdata_q <= shreg_q[WORD_W-1];
                    shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                    sent_q  <= CNT_W'(1);
                end
                ST_DATA: begin
                    if (sent_q == LAST_CNT) begin
                        sdata_q <= 1'b0;
                    end else begin
                        sdata_q <= shreg_q[WORD_W-1];
                        shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                        sent_q  <= sent_q + 1'b1;
                    end
                end
                ST_IDLE, ST_PAD: begin
                    sdata_q <= 1'b0;
                end
            endcase
        end
    end

    assign sdata = sdata_q;

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import aso_pkg::*;
#(
    parameter int WORD_W        = 18,
    parameter int SCLK_DIV_LOG2 = 2,
    parameter int LRCK_DIV_LOG2 = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              fmt_i2s,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    input  logic              sclk_in,
    input  logic              lrck_in,
    output logic              sclk_out,
    output logic              lrck_out,
    output logic              sdata
);
    bit_evt_t          mst_evt;
    bit_evt_t          slv_evt;
    bit_evt_t          evt;
    logic [WORD_W-1:0] frame_left;
    logic [WORD_W-1:0] frame_right;

    aso_master_timer #(
        .SCLK_DIV_LOG2 (SCLK_DIV_LOG2),
        .LRCK_DIV_LOG2 (LRCK_DIV_LOG2)
    ) u_timer (
        .mclk    (mclk),
        .rst_n   (rst_n),
        .enable  (!slave_mode),
        .fmt_i2s (fmt_i2s),
        .sclk_o  (sclk_out),
        .lrck_o  (lrck_out),
        .evt     (mst_evt)
    );

    aso_slave_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .mclk    (mclk),
        .rst_n   (rst_n),
        .enable  (slave_mode),
        .fmt_i2s (fmt_i2s),
        .sclk_i  (sclk_in),
        .lrck_i  (lrck_in),
        .evt     (slv_evt)
    );

    assign evt = slave_mode ? slv_evt : mst_evt;

    aso_word_hold #(
        .WORD_W (WORD_W)
    ) u_hold (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .left_word   (left_word),
        .right_word  (right_word),
        .capture     (evt.half_start && evt.left),
        .frame_left  (frame_left),
        .frame_right (frame_right)
    );

    aso_tx_fsm #(
        .WORD_W (WORD_W)
    ) u_fsm (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .fmt_i2s     (fmt_i2s),
        .evt         (evt),
        .frame_left  (frame_left),
        .frame_right (frame_right),
        .sdata       (sdata)
    );

endmodule

// File: rtl/aso_checker.sv
module aso_checker #(
    parameter int WORD_W = 18
) (
    input logic mclk,
    input logic rst_n,
    input logic slave_mode,
    input logic fmt_i2s,
    input logic sclk_out,
    input logic lrck_out,
    input logic sdata
);
    // independent slot counter: bit clock falls since the last word clock change
    logic [5:0] slot_q;
    logic [5:0] cur_slot;
    logic       sclk_q;
    logic       lrck_q;

    always_comb begin
        if (lrck_out != lrck_q) begin
            cur_slot = '0;
        end else if (sclk_q && !sclk_out && slot_q != 6'd63) begin
            cur_slot = slot_q + 1'b1;
        end else begin
            cur_slot = slot_q;
        end
    end

    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            slot_q <= 6'd63;
            sclk_q <= 1'b0;
            lrck_q <= lrck_out;
        end else begin
            slot_q <= cur_slot;
            sclk_q <= sclk_out;
            lrck_q <= lrck_out;
        end
    end

    AST_SCLK_HIGH_TWO: assert property (@(posedge mclk) disable iff (!rst_n)
        (!slave_mode && $rose(sclk_out)) |=> sclk_out); // R2
    AST_SCLK_LOW_TWO: assert property (@(posedge mclk) disable iff (!rst_n)
        (!slave_mode && $fell(sclk_out)) |=> !sclk_out); // R2
    AST_LRCK_ON_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
        (!slave_mode && !$stable(lrck_out)) |-> $fell(sclk_out)); // R2
    AST_SDATA_ON_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
        (!slave_mode && !$stable(sdata)) |-> $fell(sclk_out)); // R5
    AST_PAD_LOW_LJ: assert property (@(posedge mclk) disable iff (!rst_n)
        (!slave_mode && !fmt_i2s && cur_slot >= 6'(WORD_W)) |-> !sdata); // R8
    AST_PAD_LOW_I2S: assert property (@(posedge mclk) disable iff (!rst_n)
        (!slave_mode && fmt_i2s && (cur_slot == 6'd0 || cur_slot > 6'(WORD_W))) |-> !sdata); // R8
    AST_SLAVE_QUIET: assert property (@(posedge mclk) disable iff (!rst_n)
        slave_mode |-> (!sclk_out && !lrck_out)); // R9

endmodule

bind audio_serial_tx aso_checker #(.WORD_W(WORD_W)) u_chk (
    .mclk       (mclk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .fmt_i2s    (fmt_i2s),
    .sclk_out   (sclk_out),
    .lrck_out   (lrck_out),
    .sdata      (sdata)
);

// File: tb/sim_audio_serial_tx.sv
module sim_audio_serial_tx;
    localparam int CLK_PERIOD = 10;
    localparam int W = 18;
    localparam int NVEC = 6;
    // each entry: {left, right}
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {18'h20000, 18'h1FFFF},
        {18'h1FFFF, 18'h20000},
        {18'h3FFFF, 18'h00001},
        {18'h2AAAA, 18'h15555},
        {18'h12345, 18'h2ABCD},
        {18'h00000, 18'h3FFFF}
    };

    logic         mclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         slave_mode = 1'b0;
    logic         fmt_i2s = 1'b0;
    logic         word_valid = 1'b0;
    logic [W-1:0] left_word = '0;
    logic [W-1:0] right_word = '0;
    logic         sclk_in = 1'b0;
    logic         lrck_in = 1'b0;
    logic         sclk_out;
    logic         lrck_out;
    logic         sdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    audio_serial_tx u0 (
        .mclk       (mclk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .fmt_i2s    (fmt_i2s),
        .word_valid (word_valid),
        .left_word  (left_word),
        .right_word (right_word),
        .sclk_in    (sclk_in),
        .lrck_in    (lrck_in),
        .sclk_out   (sclk_out),
        .lrck_out   (lrck_out),
        .sdata      (sdata)
    );

    initial forever #(CLK_PERIOD/2) mclk = ~mclk;

    // external clock source for slave mode: bit clock period of 8 mclk
    bit slv_run = 1'b0;
    int slv_slots = 32;
    initial begin
        int ph;
        int slot;
        bit half;
        ph = 0; slot = 0; half = 1'b0;
        forever begin
            @(negedge mclk);
            if (!slv_run) begin
                ph = 0; slot = 0; half = 1'b0;
            end else begin
                if (ph == 0) begin
                    sclk_in = 1'b0;
                    if (slot == 0) lrck_in = fmt_i2s ? half : !half;
                end
                if (ph == 4) sclk_in = 1'b1;
                if (ph == 7) begin
                    ph = 0;
                    if (slot == slv_slots - 1) begin
                        slot = 0;
                        half = !half;
                    end else begin
                        slot++;
                    end
                end else begin
                    ph++;
                end
            end
        end
    end

    // receiver model: samples sdata on each rising bit clock
    logic         rx_sck_q, rx_lr_q, rx_lr_rise;
    logic         rx_sck, rx_lr, rx_isl;
    bit           cur_left, left_seen;
    int           bitpos, slot_i;
    logic [W-1:0] acc_l, acc_r, rx_l, rx_r;
    int           rx_cnt = 0;
    int           pad_err = 0;
    logic         edge_sd;

    always @(negedge mclk) begin
        rx_sck = slave_mode ? sclk_in : sclk_out;
        rx_lr  = slave_mode ? lrck_in : lrck_out;
        if (!rst_n) begin
            rx_sck_q = rx_sck; rx_lr_q = rx_lr; rx_lr_rise = rx_lr;
            cur_left = 1'b0; left_seen = 1'b0; bitpos = 0;
            acc_l = '0; acc_r = '0;
        end else begin
            if (!slave_mode && rx_lr != rx_lr_q && (fmt_i2s ? !rx_lr : rx_lr))
                edge_sd = sdata;
            if (rx_sck && !rx_sck_q) begin
                rx_isl = fmt_i2s ? !rx_lr : rx_lr;
                if (rx_lr != rx_lr_rise) begin
                    if (rx_isl && left_seen && !cur_left) begin
                        rx_l = acc_l; rx_r = acc_r; rx_cnt++;
                    end
                    if (rx_isl) left_seen = 1'b1;
                    cur_left = rx_isl;
                    bitpos = 0;
                    if (rx_isl) acc_l = '0; else acc_r = '0;
                end
                slot_i = bitpos - (fmt_i2s ? 1 : 0);
                if (slot_i >= 0 && slot_i < W) begin
                    if (cur_left) acc_l = {acc_l[W-2:0], sdata};
                    else          acc_r = {acc_r[W-2:0], sdata};
                end else if (left_seen && sdata !== 1'b0) begin
                    pad_err++;
                end
                bitpos++;
                rx_lr_rise = rx_lr;
            end
            rx_sck_q = rx_sck;
            rx_lr_q = rx_lr;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_pub();
        int c;
        c = rx_cnt;
        while (rx_cnt == c) @(negedge mclk);
    endtask

    task automatic write_pair(input logic [W-1:0] l, input logic [W-1:0] r);
        left_word = l; right_word = r; word_valid = 1'b1;
        @(negedge mclk);
        word_valid = 1'b0;
    endtask

    task automatic do_reset(input bit slv, input bit i2s, input int slots);
        slv_run = 1'b0;
        rst_n = 1'b0;
        slave_mode = slv; fmt_i2s = i2s; slv_slots = slots;
        sclk_in = 1'b0; lrck_in = 1'b0;
        repeat (5) @(negedge mclk);
        // R11: reset levels
        check(sdata == 1'b0 && sclk_out == 1'b0, "R11 reset sdata/sclk_out",
              {sdata, sclk_out}, 0);
        if (slv) check(lrck_out == 1'b0, "R9 slave lrck_out low", lrck_out, 0);
        else     check(lrck_out == !i2s, "R11 reset lrck_out level", lrck_out, !i2s);
        pad_err = 0;
        rst_n = 1'b1;
        slv_run = slv;
    endtask

    task automatic run_cfg(input bit slv, input bit i2s);
        logic [W-1:0] pl, pr, vl, vr;
        int nz;
        do_reset(slv, i2s, 32);
        if (!slv) begin
            nz = 0;
            repeat (120) begin
                @(negedge mclk);
                if (sdata !== 1'b0) nz++;
            end
            check(nz == 0, "R11 idle sdata low before first word clock edge", nz, 0);
        end
        wait_pub(); wait_pub();
        pl = '0; pr = '0;
        for (int i = 0; i < NVEC; i++) begin
            vl = VEC[i][2*W-1:W];
            vr = VEC[i][W-1:0];
            wait_pub();
            write_pair(vl, vr);
            wait_pub();
            check(rx_l == pl && rx_r == pr, "R7 frame in flight keeps held pair",
                  {rx_l[15:0], rx_r[15:0]}, {pl[15:0], pr[15:0]});
            wait_pub();
            check(rx_l == vl, i2s ? "R4 R1 left word" : "R3 R1 left word", rx_l, vl);
            check(rx_r == vr, "R6 R1 right word", rx_r, vr);
            if (slv) check(slave_mode && sclk_out == 1'b0 && lrck_out == 1'b0,
                           "R9 slave outputs quiet", {sclk_out, lrck_out}, 0);
            if (!slv && !i2s)
                check(edge_sd == vl[W-1], "R3 MSB with word clock edge", edge_sd, vl[W-1]);
            pl = vl; pr = vr;
        end
        check(pad_err == 0, "R8 non-data slots low", pad_err, 0);
    endtask

    task automatic master_timing();
        int n;
        do_reset(1'b0, 1'b0, 32);
        while (sclk_out !== 1'b0) @(negedge mclk);
        while (sclk_out !== 1'b1) @(negedge mclk);
        n = 0;
        while (sclk_out === 1'b1) begin n++; @(negedge mclk); end
        check(n == 2, "R2 sclk_out high time", n, 2);
        n = 0;
        while (sclk_out === 1'b0) begin n++; @(negedge mclk); end
        check(n == 2, "R2 sclk_out low time", n, 2);
        while (lrck_out !== 1'b0) @(negedge mclk);
        while (lrck_out !== 1'b1) @(negedge mclk);
        n = 0;
        do begin n++; @(negedge mclk); end while (lrck_out !== 1'b0);
        while (lrck_out !== 1'b1) begin n++; @(negedge mclk); end
        check(n == 256, "R2 lrck_out period", n, 256);
    endtask

    task automatic short_frame(input bit i2s);
        logic [W-1:0] vl, vr;
        do_reset(1'b1, i2s, 16);
        wait_pub(); wait_pub();
        vl = 18'h2ABCD; vr = 18'h15555;
        wait_pub();
        write_pair(vl, vr);
        wait_pub(); wait_pub();
        check(rx_l == (vl >> (i2s ? 3 : 2)), "R10 short frame left truncated",
              rx_l, vl >> (i2s ? 3 : 2));
        check(rx_r == (vr >> (i2s ? 3 : 2)), "R10 short frame right truncated",
              rx_r, vr >> (i2s ? 3 : 2));
    endtask

    initial begin
        master_timing();
        run_cfg(1'b0, 1'b0);
        run_cfg(1'b0, 1'b1);
        run_cfg(1'b1, 1'b0);
        run_cfg(1'b1, 1'b1);
        short_frame(1'b0);
        short_frame(1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge mclk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule